// File: doc/BRIEF.md
# Cross-Domain Pulse Shortener

This block takes a timing pulse from an external receiver and turns it into a one-cycle pulse in the local clock domain. The receiver runs on its own clock, so its pulse is asynchronous to the local clock. The pulse recurs once per second and stays high for about ten microseconds. With the local clock at 100 MHz, a one-cycle output pulse lasts 10 ns. For every incoming pulse the block emits exactly one output pulse, however long the input stays high.

The input first passes through a chain of `SYNC_STAGES` flip-flops (at least two) that limits metastability. A three-state machine watches the synchronized level and has these states:

- `ST_ARMED`: waiting for the synchronized level to be high.
- `ST_FIRE`: the one cycle in which the output is high.
- `ST_HELD`: the input is still high and the block waits for it to fall.

The machine has these transitions:

- ARMED→FIRE on a high synchronized level.
- FIRE→HELD if the level is still high.
- FIRE→ARMED if the level has already dropped.
- HELD→ARMED when the level falls.
- ARMED→ARMED and HELD→HELD otherwise.

The output is a decode of `ST_FIRE` from the state register. An asynchronous active-high reset clears both the synchronizer and the state machine.

Top module: `pps_tick_shaper`

## Requirements
- R1: While `arst` is high, every synchronizer flop holds 0 and the state machine is in `ST_ARMED`.
- R2: A rise of `pulse_in` that is first captured at clock edge N makes `tick_out` high during the cycle that follows edge N + `SYNC_STAGES`. With the default of 2 stages, that is three edges after the input change.
- R3: `tick_out` is never high for two consecutive cycles.
- R4: While `pulse_in` stays high, `tick_out` is raised once only, including across a 1000-cycle (10 µs) hold.
- R5: A new rise of `pulse_in` after it has been low for at least one captured cycle produces a new pulse with the same latency as in R2.
- R6: An input pulse that is high across only one or two clock edges still yields exactly one output pulse.
- R7: If `pulse_in` is already high when reset is released, exactly one pulse follows, with the same latency as in R2 counted from the release.
- R8: `tick_out` stays low while `arst` is high, whatever `pulse_in` does.
- R9: A fall of `pulse_in` never produces a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock (100 MHz) |
| arst | input | 1 | Asynchronous reset, active high |
| pulse_in | input | 1 | Long pulse from the foreign clock domain |
| tick_out | output | 1 | One-cycle pulse per input pulse |

## Verification
Each rise of `pulse_in` is driven on a falling clock edge. Its pulse is due at the falling-edge sample taken `SYNC_STAGES` + 1 rising edges later. That count covers the synchronizer stages plus the state register. The driver pushes that cycle number, tagged with its requirement, into a scoreboard queue at the moment it drives the input. A monitor samples `tick_out` on every falling edge. It pops and compares an entry when a pulse appears. It reports a pulse with no queued entry as a spurious pulse, and an entry whose cycle has passed as a missed pulse. Falls of the input, long holds and reset phases push nothing, so any pulse they cause is caught as spurious.

// File: rtl/pts_pkg.sv
package pts_pkg;

    // States of the edge machine
    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_FIRE  = 2'd1,
        ST_HELD  = 2'd2
    } pts_state_e;

    localparam int unsigned PTS_MIN_STAGES = 2;

endpackage

// File: rtl/pts_sync_chain.sv
module pts_sync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    input  logic async_d,
    output logic sync_q
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] stage_q;

    // One flop per stage; stage 0 samples the foreign signal.
    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
        if (gi == 0) begin : g_first
            always_ff @(posedge clk or posedge arst) begin
                if (arst) stage_q[gi] <= 1'b0;
                else      stage_q[gi] <= async_d;
            end
        end else begin : g_next
            always_ff @(posedge clk or posedge arst) begin
                if (arst) stage_q[gi] <= 1'b0;
                else      stage_q[gi] <= stage_q[gi-1];
            end
        end
    end

    assign sync_q = stage_q[LAST];

    // R1: chain is cleared whenever reset is seen at a clock edge
    p_chain_clear_r1: assert property (@(posedge clk) arst |-> (stage_q == '0))
        else $error("R1: synchronizer not cleared in reset");

endmodule

// File: rtl/pts_edge_fsm.sv
module pts_edge_fsm
    import pts_pkg::*;
(
    input  logic clk,
    input  logic arst,
    input  logic level_i,
    output logic tick_o
);

    pts_state_e state_q;
    pts_state_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (level_i)  state_d = ST_FIRE;
            ST_FIRE:  state_d = level_i ? ST_HELD : ST_ARMED;
            ST_HELD:  if (!level_i) state_d = ST_ARMED;
            default:  state_d = ST_ARMED;
        endcase
    end

    // State register
    always_ff @(posedge clk or posedge arst) begin
        if (arst) state_q <= ST_ARMED;
        else      state_q <= state_d;
    end

    // Output decode
    always_comb begin
        tick_o = 1'b0;
        unique case (state_q)
            ST_FIRE:  tick_o = 1'b1;
            ST_ARMED,
            ST_HELD:  tick_o = 1'b0;
            default:  tick_o = 1'b0;
        endcase
    end

    p_armed_in_reset_r1: assert property (@(posedge clk) arst |-> (state_q == ST_ARMED))
        else $error("R1: machine not armed in reset");

    p_fire_on_rise_r2: assert property (@(posedge clk) disable iff (arst)
        (state_q == ST_ARMED && level_i) |=> tick_o)
        else $error("R2: rise of synchronized level did not fire");

    p_tick_after_level_r2: assert property (@(posedge clk) disable iff (arst)
        tick_o |-> $past(level_i))
        else $error("R2: pulse without preceding synchronized high");

    p_single_cycle_r3: assert property (@(posedge clk) disable iff (arst)
        tick_o |=> !tick_o)
        else $error("R3: pulse wider than one cycle");

    p_no_refire_r4: assert property (@(posedge clk) disable iff (arst)
        (state_q == ST_HELD) |=> !tick_o)
        else $error("R4: re-fire while input held");

    p_quiet_in_reset_r8: assert property (@(posedge clk) arst |-> !tick_o)
        else $error("R8: pulse during reset");

    p_no_fall_fire_r9: assert property (@(posedge clk) disable iff (arst)
        (!level_i && state_q != ST_ARMED) |=> !tick_o)
        else $error("R9: pulse on falling level");

endmodule

// File: rtl/pps_tick_shaper.sv
module pps_tick_shaper
    import pts_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    input  logic pulse_in,
    output logic tick_out
);

    localparam int unsigned STAGES_USED =
        (SYNC_STAGES < PTS_MIN_STAGES) ? PTS_MIN_STAGES : SYNC_STAGES;

    logic level_sync;

    pts_sync_chain #(
        .STAGES (STAGES_USED)
    ) u_sync (
        .clk     (clk),
        .arst    (arst),
        .async_d (pulse_in),
        .sync_q  (level_sync)
    );

    pts_edge_fsm u_fsm (
        .clk     (clk),
        .arst    (arst),
        .level_i (level_sync),
        .tick_o  (tick_out)
    );

endmodule

// File: tb/pps_tick_shaper_bench.sv
module pps_tick_shaper_bench;

    localparam int CLK_PERIOD = 10;
    localparam int STAGES     = 2;
    localparam int LATENCY    = STAGES + 1;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        int    cyc;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic arst = 1'b1;
    logic pulse_in = 1'b0;
    logic tick_out;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic prev_tick = 1'b0;
    exp_t sb[$];

    pps_tick_shaper #(.SYNC_STAGES(STAGES)) u_pps_tick_shaper (
        .clk      (clk),
        .arst     (arst),
        .pulse_in (pulse_in),
        .tick_out (tick_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare observed pulses against the scoreboard
    always @(negedge clk) begin
        if (!arst) begin
            if (tick_out === 1'b1) begin
                checks++;
                if (prev_tick === 1'b1) begin
                    errors++;
                    $display("FAIL R3: pulse high two cycles at cycle %0d (actual 1, expected 0)", cyc);
                end else if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL R4 or R9: spurious pulse at cycle %0d (actual 1, expected 0)", cyc);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (e.cyc != cyc) begin
                        errors++;
                        $display("FAIL %s: pulse at cycle %0d, expected cycle %0d", e.tag, cyc, e.cyc);
                    end
                end
            end
            if (sb.size() > 0 && sb[0].cyc < cyc) begin
                exp_t m;
                m = sb.pop_front();
                checks++;
                errors++;
                $display("FAIL %s: missed pulse (actual none, expected at cycle %0d)", m.tag, m.cyc);
            end
        end
        prev_tick = tick_out;
    end

    task automatic raise(input string tag);
        exp_t e;
        @(negedge clk);
        pulse_in = 1'b1;
        e.cyc = cyc + LATENCY;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic lower();
        @(negedge clk);
        pulse_in = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_low(input string tag);
        checks++;
        if (tick_out !== 1'b0) begin
            errors++;
            $display("FAIL %s: tick_out actual %b, expected 0", tag, tick_out);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung (actual timeout, expected completion)");
        finish_run();
    end

    initial begin
        // R1 / R8: reset holds output low while the input toggles
        idle(1);
        check_low("R1");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            pulse_in = ~pulse_in;
            check_low("R8");
        end
        @(negedge clk);
        pulse_in = 1'b0;
        idle(3);
        check_low("R8");
        @(negedge clk);
        arst = 1'b0;
        idle(6);
        check_low("R1");

        // R2 / R4: 10 us hold yields one pulse; R9: fall yields none
        raise("R2");
        idle(1000);
        lower();
        idle(10);

        // R6: narrow inputs
        raise("R6");
        lower();
        idle(8);
        raise("R6");
        idle(1);
        lower();
        idle(8);

        // R5: back-to-back with one low cycle between
        raise("R5");
        idle(5);
        lower();
        raise("R5");
        idle(4);
        lower();
        idle(3);
        raise("R5");
        idle(20);
        lower();
        idle(10);

        // R7: input already high at reset release
        @(negedge clk);
        arst = 1'b1;
        pulse_in = 1'b1;
        idle(3);
        check_low("R8");
        begin
            exp_t e;
            @(negedge clk);
            arst = 1'b0;
            e.cyc = cyc + LATENCY;
            e.tag = "R7";
            sb.push_back(e);
        end
        idle(50);
        lower();
        idle(10);

        // R9: final quiet period after a fall
        check_low("R9");
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R2: %0d expected pulses never seen (actual %0d, expected 0)", sb.size(), sb.size());
        end
        finish_run();
    end

endmodule